// File: doc/BRIEF.md
# Parity-checked cache line store

This block holds a small direct-indexed array of cache lines. Every line carries a tag, a 32-byte data block, one usage bit and four modified bits. Each stored field carries even parity. The parity is produced when the field is written and is kept next to it. When the field is read back, the parity is recomputed and compared with the stored copy. A consumer sees three ports. A write port updates a tag, a byte-masked data word or the status bits. A lookup port returns one data word, a hit indication and error flags. A flush port reads out a whole line together with its status bits.

Faults can be forced for test. A three-bit injection selector perturbs the parity checker itself, so the stored contents are never altered and the same line reads clean again once the selector returns to zero. Detected faults are reported only while the parity enable input is high. Each report names the set, the field classes that failed, and whether the fault came from a lookup or from a flush. Recovery is a single invalidate-all pulse. It clears every valid bit at one set per clock, and a busy output stays high during the sweep.

Top module: `plc_line_store`

## Requirements
- R1: After reset no line is valid, busy_o is low and rd_vld_o, fl_vld_o and err_vld_o are all low.
- R2: A tag write (wr_kind_i = 0) stores the tag and marks the set valid. A lookup accepted in cycle N returns rd_vld_o, rd_hit_o and rd_data_o after the next rising edge. rd_hit_o is 1 only when the set is valid and its tag equals rd_tag_i. Byte b of word w is line byte w*4+b and appears on bits [8b+7:8b] of the word.
- R3: A data write (wr_kind_i = 1) changes only the bytes of the addressed word whose wr_be_i bit is set. A status write (wr_kind_i = 2) replaces the usage bit and the four modified bits.
- R4: Parity is even and is stored per data byte, per tag half (split at TAG_W/2), for the usage bit and for each modified bit. With inj_sel_i = 0, no lookup or flush ever reports an error.
- R5: The err_flags_o bits mean: 0 tag, 1 data, 2 usage, 3 modified, 4 two or more failing data bytes, 5 flush-time fault. On a lookup, inj_sel_i values give these flags: 1 gives tag; 2 gives data (byte 0 of the word); 3 gives usage; 4 gives modified (bit 0); 5 gives data and multi (bytes 0 and 1 of the word). Value 6 has no effect on a lookup. The flags appear in the same cycle as rd_vld_o, and rd_data_o is still returned.
- R6: A flush (fl_en_i) returns the line on fl_data_o, with line byte k on bits [8k+7:8k], together with fl_use_o and fl_mod_o. Any fault found by a flush also sets flag bit 5. inj_sel_i = 6 fails line byte 0 only during a flush. Values 2 and 5 act on line bytes 0 and 0–1 respectively.
- R7: An inv_all_i pulse accepted while idle raises busy_o at the next edge and holds it for exactly SETS cycles. Once busy_o falls, every lookup misses.
- R8: While par_en_i is low, err_vld_o and err_flags_o stay zero whatever inj_sel_i holds.
- R9: While busy_o is high, writes, lookups, flushes and further invalidate pulses are ignored.
- R10: Faults are reported only for valid lines, and err_set_o gives the set that was checked.
- R11: When rd_en_i and fl_en_i are high in the same cycle, the lookup is served and the flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| par_en_i | input | 1 | Enables error reporting |
| inj_sel_i | input | 3 | Fault injection selector (0 = none) |
| wr_en_i | input | 1 | Write request |
| wr_kind_i | input | 2 | 0 tag, 1 data word, 2 status bits |
| wr_set_i | input | SET_W | Set being written |
| wr_tag_i | input | TAG_W | Tag to store |
| wr_word_i | input | WI_W | Word index inside the line |
| wr_data_i | input | WORD_W | Data word to store |
| wr_be_i | input | WORD_BYTES | Byte enables for the data word |
| wr_use_i | input | 1 | Usage bit to store |
| wr_mod_i | input | MOD_N | Modified bits to store |
| rd_en_i | input | 1 | Lookup request |
| rd_set_i | input | SET_W | Set to look up |
| rd_word_i | input | WI_W | Word to return |
| rd_tag_i | input | TAG_W | Tag to compare |
| rd_vld_o | output | 1 | Lookup result valid |
| rd_hit_o | output | 1 | Set valid and tag matched |
| rd_data_o | output | WORD_W | Returned data word |
| fl_en_i | input | 1 | Flush-check request |
| fl_set_i | input | SET_W | Set to read out |
| fl_vld_o | output | 1 | Flush result valid |
| fl_data_o | output | LINE_W | Whole line |
| fl_use_o | output | 1 | Usage bit of the line |
| fl_mod_o | output | MOD_N | Modified bits of the line |
| inv_all_i | input | 1 | Start invalidating every set |
| busy_o | output | 1 | Invalidate sweep in progress |
| err_vld_o | output | 1 | A fault is reported |
| err_set_o | output | SET_W | Set of the reported fault |
| err_flags_o | output | 6 | Fault class flags |

## Verification
Stored parity always matches its data, so a fault in the generation or comparison logic shows up through the injection selector. Such a fault gives a wrong or missing flag on the very result cycle of the lookup or flush that touched the line. A bad valid bit or a stalled sweep counter shows up as a wrong hit, or as a missing error report on the first lookup after busy_o falls. The busy window length is seen within SETS+1 cycles of the pulse. The reference model tracks every stored byte, so a mis-steered byte write is caught as a data mismatch on the next read of that word.

// File: rtl/plc_pkg.sv
package plc_pkg;
   localparam int ERR_W    = 6;
   localparam int EB_TAG   = 0;
   localparam int EB_DATA  = 1;
   localparam int EB_USE   = 2;
   localparam int EB_MOD   = 3;
   localparam int EB_MULTI = 4;
   localparam int EB_FLUSH = 5;

   typedef enum logic [2:0] {
      INJ_NONE  = 3'd0,
      INJ_TAG   = 3'd1,
      INJ_DATA  = 3'd2,
      INJ_USE   = 3'd3,
      INJ_MOD   = 3'd4,
      INJ_MULTI = 3'd5,
      INJ_FLUSH = 3'd6,
      INJ_RSVD  = 3'd7
   } inj_e;

   typedef enum logic [1:0] {
      WK_TAG  = 2'd0,
      WK_DATA = 2'd1,
      WK_STAT = 2'd2,
      WK_NONE = 2'd3
   } wkind_e;
endpackage

// File: rtl/plc_par_vec.sv
module plc_par_vec #(
   parameter int GROUPS = 4,
   parameter int GW     = 8
) (
   input  logic [GROUPS*GW-1:0] din_i,
   output logic [GROUPS-1:0]    par_o
);
   if (GROUPS < 1 || GW < 1) begin : g_bad_cfg
      $error("plc_par_vec: GROUPS and GW must be positive");
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign par_o[g] = ^din_i[g*GW +: GW];
   end
endmodule

// File: rtl/plc_meta_chk.sv
module plc_meta_chk #(
   parameter int TAG_W = 20,
   parameter int MOD_N = 4
) (
   input  logic [TAG_W-1:0] tag_i,
   input  logic [1:0]       tagp_i,
   input  logic             use_i,
   input  logic             usep_i,
   input  logic [MOD_N-1:0] mod_i,
   input  logic [MOD_N-1:0] modp_i,
   input  logic             inj_tag_i,
   input  logic             inj_use_i,
   input  logic             inj_mod_i,
   output logic             tag_bad_o,
   output logic             use_bad_o,
   output logic             mod_bad_o
);
   localparam int TAG_LO = TAG_W / 2;

   if (TAG_W < 2) begin : g_bad_tag
      $error("plc_meta_chk: TAG_W must be at least 2");
   end

   logic [1:0]       tag_calc;
   logic [MOD_N-1:0] mod_calc;

   assign tag_calc  = {^tag_i[TAG_W-1:TAG_LO], ^tag_i[TAG_LO-1:0]} ^ {1'b0, inj_tag_i};
   assign mod_calc  = mod_i ^ MOD_N'(inj_mod_i);
   assign tag_bad_o = |(tag_calc ^ tagp_i);
   assign use_bad_o = (use_i ^ inj_use_i) ^ usep_i;
   assign mod_bad_o = |(mod_calc ^ modp_i);
endmodule

// File: rtl/plc_inv_seq.sv
module plc_inv_seq #(
   parameter int SETS = 16
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   output logic                    busy_o,
   output logic [$clog2(SETS)-1:0] idx_o
);
   localparam int SW = $clog2(SETS);

   logic [SW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else begin
         if (cnt_q == SW'(SETS - 1)) busy_q <= 1'b0;
         cnt_q <= cnt_q + SW'(1);
      end
   end

   assign busy_o = busy_q;
   assign idx_o  = cnt_q;

   a_r7_sweep_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && cnt_q == SW'(SETS - 1)) |=> !busy_q);
   a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && cnt_q != SW'(SETS - 1)) |=> busy_q);
endmodule

// File: rtl/plc_line_store.sv
module plc_line_store
   import plc_pkg::*;
#(
   parameter int SETS       = 16,
   parameter int TAG_W      = 20,
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 4,
   parameter int MOD_N      = 4,
   localparam int SET_W     = $clog2(SETS),
   localparam int WORDS     = LINE_BYTES / WORD_BYTES,
   localparam int WI_W      = $clog2(WORDS),
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int WORD_W    = WORD_BYTES * 8
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  par_en_i,
   input  logic [2:0]            inj_sel_i,
   input  logic                  wr_en_i,
   input  logic [1:0]            wr_kind_i,
   input  logic [SET_W-1:0]      wr_set_i,
   input  logic [TAG_W-1:0]      wr_tag_i,
   input  logic [WI_W-1:0]       wr_word_i,
   input  logic [WORD_W-1:0]     wr_data_i,
   input  logic [WORD_BYTES-1:0] wr_be_i,
   input  logic                  wr_use_i,
   input  logic [MOD_N-1:0]      wr_mod_i,
   input  logic                  rd_en_i,
   input  logic [SET_W-1:0]      rd_set_i,
   input  logic [WI_W-1:0]       rd_word_i,
   input  logic [TAG_W-1:0]      rd_tag_i,
   output logic                  rd_vld_o,
   output logic                  rd_hit_o,
   output logic [WORD_W-1:0]     rd_data_o,
   input  logic                  fl_en_i,
   input  logic [SET_W-1:0]      fl_set_i,
   output logic                  fl_vld_o,
   output logic [LINE_W-1:0]     fl_data_o,
   output logic                  fl_use_o,
   output logic [MOD_N-1:0]      fl_mod_o,
   input  logic                  inv_all_i,
   output logic                  busy_o,
   output logic                  err_vld_o,
   output logic [SET_W-1:0]      err_set_o,
   output logic [ERR_W-1:0]      err_flags_o
);
   localparam int TAG_LO = TAG_W / 2;

   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("plc_line_store: SETS must be a power of two of at least 2");
   end
   if (WORD_BYTES < 2 || LINE_BYTES % WORD_BYTES != 0 || WORDS < 2) begin : g_bad_line
      $error("plc_line_store: line must hold at least two words of at least two bytes");
   end

   // ---------------- storage ----------------
   logic [TAG_W-1:0]      tag_q  [SETS];
   logic [1:0]            tagp_q [SETS];
   logic [LINE_W-1:0]     dat_q  [SETS];
   logic [LINE_BYTES-1:0] datp_q [SETS];
   logic [MOD_N-1:0]      mod_q  [SETS];
   logic [MOD_N-1:0]      modp_q [SETS];
   logic [SETS-1:0]       vld_q, use_q, usep_q;

   inj_e   inj;
   wkind_e wkind;
   logic   busy_w, acc, wr_go, rd_go, fl_go;
   logic [SET_W-1:0] clr_idx;

   assign inj   = inj_e'(inj_sel_i);
   assign wkind = wkind_e'(wr_kind_i);
   assign acc   = !busy_w;
   assign wr_go = wr_en_i && acc;
   assign rd_go = rd_en_i && acc;
   assign fl_go = fl_en_i && !rd_en_i && acc;

   plc_inv_seq #(.SETS(SETS)) u_inv (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(inv_all_i),
      .busy_o (busy_w),
      .idx_o  (clr_idx)
   );
   assign busy_o = busy_w;

   logic [WORD_BYTES-1:0] wpar;
   plc_par_vec #(.GROUPS(WORD_BYTES), .GW(8)) u_wpar (.din_i(wr_data_i), .par_o(wpar));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < SETS; i++) begin
            tag_q[i]  <= '0;
            tagp_q[i] <= '0;
            dat_q[i]  <= '0;
            datp_q[i] <= '0;
            mod_q[i]  <= '0;
            modp_q[i] <= '0;
         end
         vld_q  <= '0;
         use_q  <= '0;
         usep_q <= '0;
      end else begin
         if (wr_go) begin
            case (wkind)
               WK_TAG: begin
                  tag_q[wr_set_i]  <= wr_tag_i;
                  tagp_q[wr_set_i] <= {^wr_tag_i[TAG_W-1:TAG_LO], ^wr_tag_i[TAG_LO-1:0]};
                  vld_q[wr_set_i]  <= 1'b1;
               end
               WK_DATA: begin
                  for (int b = 0; b < WORD_BYTES; b++) begin
                     if (wr_be_i[b]) begin
                        dat_q[wr_set_i][(int'(wr_word_i)*WORD_BYTES + b)*8 +: 8] <= wr_data_i[b*8 +: 8];
                        datp_q[wr_set_i][int'(wr_word_i)*WORD_BYTES + b]        <= wpar[b];
                     end
                  end
               end
               WK_STAT: begin
                  use_q[wr_set_i]  <= wr_use_i;
                  usep_q[wr_set_i] <= wr_use_i;
                  mod_q[wr_set_i]  <= wr_mod_i;
                  modp_q[wr_set_i] <= wr_mod_i;
               end
               default: ;
            endcase
         end
         if (busy_w) vld_q[clr_idx] <= 1'b0;
      end
   end

   // ---------------- lookup check ----------------
   logic [LINE_W-1:0]     rline;
   logic [WORD_W-1:0]     rword;
   logic [WORD_BYTES-1:0] rpar_st, rpar_calc, rinj, rdm;
   logic                  r_tag_bad, r_use_bad, r_mod_bad;
   logic [ERR_W-1:0]      rflags;

   assign rline   = dat_q[rd_set_i];
   assign rword   = rline[int'(rd_word_i)*WORD_W +: WORD_W];
   assign rpar_st = datp_q[rd_set_i][int'(rd_word_i)*WORD_BYTES +: WORD_BYTES];
   assign rinj    = (inj == INJ_DATA)  ? WORD_BYTES'(1) :
                    (inj == INJ_MULTI) ? WORD_BYTES'(3) : '0;

   plc_par_vec #(.GROUPS(WORD_BYTES), .GW(8)) u_rpar (.din_i(rword), .par_o(rpar_calc));
   assign rdm = rpar_calc ^ rinj ^ rpar_st;

   plc_meta_chk #(.TAG_W(TAG_W), .MOD_N(MOD_N)) u_rmeta (
      .tag_i(tag_q[rd_set_i]), .tagp_i(tagp_q[rd_set_i]),
      .use_i(use_q[rd_set_i]), .usep_i(usep_q[rd_set_i]),
      .mod_i(mod_q[rd_set_i]), .modp_i(modp_q[rd_set_i]),
      .inj_tag_i(inj == INJ_TAG), .inj_use_i(inj == INJ_USE), .inj_mod_i(inj == INJ_MOD),
      .tag_bad_o(r_tag_bad), .use_bad_o(r_use_bad), .mod_bad_o(r_mod_bad)
   );

   always_comb begin
      rflags           = '0;
      rflags[EB_TAG]   = r_tag_bad;
      rflags[EB_DATA]  = |rdm;
      rflags[EB_USE]   = r_use_bad;
      rflags[EB_MOD]   = r_mod_bad;
      rflags[EB_MULTI] = $countones(rdm) > 1;
   end

   // ---------------- flush check ----------------
   logic [LINE_W-1:0]     fline;
   logic [LINE_BYTES-1:0] fpar_calc, finj, fdm;
   logic                  f_tag_bad, f_use_bad, f_mod_bad;
   logic [ERR_W-1:0]      fflags;

   assign fline = dat_q[fl_set_i];
   assign finj  = (inj == INJ_DATA || inj == INJ_FLUSH) ? LINE_BYTES'(1) :
                  (inj == INJ_MULTI)                     ? LINE_BYTES'(3) : '0;

   plc_par_vec #(.GROUPS(LINE_BYTES), .GW(8)) u_fpar (.din_i(fline), .par_o(fpar_calc));
   assign fdm = fpar_calc ^ finj ^ datp_q[fl_set_i];

   plc_meta_chk #(.TAG_W(TAG_W), .MOD_N(MOD_N)) u_fmeta (
      .tag_i(tag_q[fl_set_i]), .tagp_i(tagp_q[fl_set_i]),
      .use_i(use_q[fl_set_i]), .usep_i(usep_q[fl_set_i]),
      .mod_i(mod_q[fl_set_i]), .modp_i(modp_q[fl_set_i]),
      .inj_tag_i(inj == INJ_TAG), .inj_use_i(inj == INJ_USE), .inj_mod_i(inj == INJ_MOD),
      .tag_bad_o(f_tag_bad), .use_bad_o(f_use_bad), .mod_bad_o(f_mod_bad)
   );

   always_comb begin
      fflags           = '0;
      fflags[EB_TAG]   = f_tag_bad;
      fflags[EB_DATA]  = |fdm;
      fflags[EB_USE]   = f_use_bad;
      fflags[EB_MOD]   = f_mod_bad;
      fflags[EB_MULTI] = $countones(fdm) > 1;
      fflags[EB_FLUSH] = f_tag_bad | f_use_bad | f_mod_bad | (|fdm);
   end

   // ---------------- result registers ----------------
   logic [SET_W-1:0] chk_set;
   logic [ERR_W-1:0] nxt_flags;

   assign chk_set = rd_go ? rd_set_i : fl_set_i;

   always_comb begin
      nxt_flags = '0;
      if (par_en_i && vld_q[chk_set]) begin
         if (rd_go)      nxt_flags = rflags;
         else if (fl_go) nxt_flags = fflags;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_vld_o    <= 1'b0;
         rd_hit_o    <= 1'b0;
         rd_data_o   <= '0;
         fl_vld_o    <= 1'b0;
         fl_data_o   <= '0;
         fl_use_o    <= 1'b0;
         fl_mod_o    <= '0;
         err_flags_o <= '0;
         err_set_o   <= '0;
      end else begin
         rd_vld_o    <= rd_go;
         fl_vld_o    <= fl_go;
         err_flags_o <= nxt_flags;
         if (rd_go) begin
            rd_hit_o  <= vld_q[rd_set_i] && (tag_q[rd_set_i] == rd_tag_i);
            rd_data_o <= rword;
         end
         if (fl_go) begin
            fl_data_o <= fline;
            fl_use_o  <= use_q[fl_set_i];
            fl_mod_o  <= mod_q[fl_set_i];
         end
         if (|nxt_flags) err_set_o <= chk_set;
      end
   end

   assign err_vld_o = |err_flags_o;

   // ---------------- assertions ----------------
   a_r8_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !par_en_i |=> (err_flags_o == '0));
   a_r5_lookup_flag_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_vld_o && !err_flags_o[EB_FLUSH]) |-> rd_vld_o);
   a_r6_flush_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl_vld_o && err_vld_o) |-> err_flags_o[EB_FLUSH]);
   a_r5_multi_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_flags_o[EB_MULTI] |-> err_flags_o[EB_DATA]);
   a_r9_idle_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (!rd_vld_o && !fl_vld_o));
   a_r7_all_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (vld_q == '0));
   a_r11_read_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_vld_o |-> !fl_vld_o);
endmodule

// File: tb/plc_line_store_tb.sv
`timescale 1ns/1ps
module plc_line_store_tb_top;
   localparam int NS = 16;
   localparam int TW = 20;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, par_en, wr_en, rd_en, fl_en, inv_all, wr_use;
   logic [2:0]    inj;
   logic [1:0]    wr_kind;
   logic [3:0]    wr_set, rd_set, fl_set, wr_mod;
   logic [TW-1:0] wr_tag, rd_tag;
   logic [2:0]    wr_word, rd_word;
   logic [31:0]   wr_data;
   logic [3:0]    wr_be;
   logic          rd_vld, rd_hit, fl_vld, fl_use, busy, err_vld;
   logic [31:0]   rd_data;
   logic [255:0]  fl_data;
   logic [3:0]    fl_mod, err_set;
   logic [5:0]    err_flags;

   plc_line_store dut_i (
      .clk_i(clk), .rst_ni(rst_n), .par_en_i(par_en), .inj_sel_i(inj),
      .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_set_i(wr_set), .wr_tag_i(wr_tag),
      .wr_word_i(wr_word), .wr_data_i(wr_data), .wr_be_i(wr_be), .wr_use_i(wr_use),
      .wr_mod_i(wr_mod), .rd_en_i(rd_en), .rd_set_i(rd_set), .rd_word_i(rd_word),
      .rd_tag_i(rd_tag), .rd_vld_o(rd_vld), .rd_hit_o(rd_hit), .rd_data_o(rd_data),
      .fl_en_i(fl_en), .fl_set_i(fl_set), .fl_vld_o(fl_vld), .fl_data_o(fl_data),
      .fl_use_o(fl_use), .fl_mod_o(fl_mod), .inv_all_i(inv_all), .busy_o(busy),
      .err_vld_o(err_vld), .err_set_o(err_set), .err_flags_o(err_flags)
   );

   // behavioural reference state
   bit          m_vld [NS];
   bit [TW-1:0] m_tag [NS];
   bit [7:0]    m_dat [NS][32];
   bit          m_use [NS];
   bit [3:0]    m_mod [NS];
   bit          m_busy;
   int          m_cnt;

   int    checks, errors;
   string cur_req;
   bit    done;

   task automatic chk(input string what, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
      end
   endtask

   task automatic cyc();
      bit acc, rgo, fgo, e_fuse, e_hit;
      bit [31:0] e_rdata;
      bit [255:0] e_fdata;
      bit [3:0] e_fmod;
      bit [5:0] e_flags;
      int s;
      acc = !m_busy;
      rgo = rd_en && acc;
      fgo = fl_en && !rd_en && acc;
      e_hit = 0; e_rdata = '0; e_fdata = '0; e_fuse = 0; e_fmod = '0; e_flags = '0;
      if (rgo) begin
         e_hit = m_vld[rd_set] && (m_tag[rd_set] == rd_tag);
         for (int b = 0; b < 4; b++) e_rdata[b*8 +: 8] = m_dat[rd_set][rd_word*4 + b];
      end
      if (fgo) begin
         for (int k = 0; k < 32; k++) e_fdata[k*8 +: 8] = m_dat[fl_set][k];
         e_fuse = m_use[fl_set];
         e_fmod = m_mod[fl_set];
      end
      s = rgo ? int'(rd_set) : int'(fl_set);
      if (par_en && (rgo || fgo) && m_vld[s]) begin
         case (inj)
            3'd1: e_flags = 6'b000001;
            3'd2: e_flags = 6'b000010;
            3'd3: e_flags = 6'b000100;
            3'd4: e_flags = 6'b001000;
            3'd5: e_flags = 6'b010010;
            3'd6: e_flags = fgo ? 6'b000010 : 6'b000000;
            default: e_flags = '0;
         endcase
         if (fgo && e_flags != 0) e_flags[5] = 1'b1;
      end
      // reference update
      if (wr_en && acc) begin
         case (wr_kind)
            2'd0: begin m_tag[wr_set] = wr_tag; m_vld[wr_set] = 1'b1; end
            2'd1: for (int b = 0; b < 4; b++)
                     if (wr_be[b]) m_dat[wr_set][wr_word*4 + b] = wr_data[b*8 +: 8];
            2'd2: begin m_use[wr_set] = wr_use; m_mod[wr_set] = wr_mod; end
            default: ;
         endcase
      end
      if (m_busy) begin
         m_vld[m_cnt] = 1'b0;
         if (m_cnt == NS - 1) m_busy = 1'b0;
         m_cnt++;
      end else if (inv_all) begin
         m_busy = 1'b1;
         m_cnt  = 0;
      end
      @(posedge clk);
      @(negedge clk);
      chk("busy", 256'(busy), 256'(m_busy));
      chk("rd_vld", 256'(rd_vld), 256'(rgo));
      chk("fl_vld", 256'(fl_vld), 256'(fgo));
      chk("err_flags", 256'(err_flags), 256'(e_flags));
      chk("err_vld", 256'(err_vld), 256'(e_flags != 0));
      if (rgo) begin
         chk("rd_hit", 256'(rd_hit), 256'(e_hit));
         chk("rd_data", 256'(rd_data), 256'(e_rdata));
      end
      if (fgo) begin
         chk("fl_data", fl_data, e_fdata);
         chk("fl_use", 256'(fl_use), 256'(e_fuse));
         chk("fl_mod", 256'(fl_mod), 256'(e_fmod));
      end
      if (e_flags != 0) chk("err_set", 256'(err_set), 256'(s));
   endtask

   task automatic idle_in();
      wr_en = 0; rd_en = 0; fl_en = 0; inv_all = 0;
   endtask

   task automatic wtag(input int s, input logic [TW-1:0] t);
      wr_en = 1; wr_kind = 2'd0; wr_set = 4'(s); wr_tag = t;
      cyc(); idle_in();
   endtask

   task automatic wdat(input int s, input int w, input logic [31:0] d, input logic [3:0] be);
      wr_en = 1; wr_kind = 2'd1; wr_set = 4'(s); wr_word = 3'(w); wr_data = d; wr_be = be;
      cyc(); idle_in();
   endtask

   task automatic wstat(input int s, input logic u, input logic [3:0] m);
      wr_en = 1; wr_kind = 2'd2; wr_set = 4'(s); wr_use = u; wr_mod = m;
      cyc(); idle_in();
   endtask

   task automatic rd(input int s, input int w, input logic [TW-1:0] t);
      rd_en = 1; rd_set = 4'(s); rd_word = 3'(w); rd_tag = t;
      cyc(); idle_in();
   endtask

   task automatic fl(input int s);
      fl_en = 1; fl_set = 4'(s);
      cyc(); idle_in();
   endtask

   function automatic logic [TW-1:0] tag_of(input int s);
      return TW'(32'hA0000 + s * 32'h111);
   endfunction

   initial begin
      checks = 0; errors = 0; done = 0; cur_req = "R1";
      rst_n = 0; par_en = 0; inj = 3'd0; idle_in();
      wr_kind = 0; wr_set = 0; wr_tag = 0; wr_word = 0; wr_data = 0; wr_be = 0;
      wr_use = 0; wr_mod = 0; rd_set = 0; rd_word = 0; rd_tag = 0; fl_set = 0;
      m_busy = 0; m_cnt = 0;
      for (int i = 0; i < NS; i++) begin
         m_vld[i] = 0; m_tag[i] = '0; m_use[i] = 0; m_mod[i] = '0;
         for (int k = 0; k < 32; k++) m_dat[i][k] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk("busy", 256'(busy), 256'(0));
      chk("rd_vld", 256'(rd_vld), 256'(0));
      chk("fl_vld", 256'(fl_vld), 256'(0));
      chk("err_vld", 256'(err_vld), 256'(0));
      rd(3, 0, 20'h0);

      // R2: tags, full words, lookups
      cur_req = "R2";
      for (int s = 0; s < NS; s++) wtag(s, tag_of(s));
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < 8; w++)
            wdat(s, w, (32'h01020304 * (s + 1)) ^ (32'h9E3779B9 >> w), 4'hF);
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < 8; w += 3) rd(s, w, tag_of(s));
      rd(7, 2, tag_of(8));

      // R3: byte masks and status writes
      cur_req = "R3";
      wdat(2, 5, 32'hDEADBEEF, 4'b0101);
      rd(2, 5, tag_of(2));
      wdat(2, 5, 32'h12345678, 4'b1000);
      rd(2, 5, tag_of(2));
      wdat(2, 5, 32'hCAFEF00D, 4'b0000);
      rd(2, 5, tag_of(2));
      wstat(2, 1'b1, 4'b1010);
      wstat(9, 1'b0, 4'b0111);
      fl(2);
      fl(9);

      // R4: clean contents report nothing
      cur_req = "R4";
      par_en = 1;
      for (int s = 0; s < NS; s++) begin
         wstat(s, 1'(s), 4'(s * 5));
         for (int w = 0; w < 8; w++) rd(s, w, tag_of(s));
         fl(s);
      end

      // R5: lookup injection per code
      cur_req = "R5";
      for (int k = 1; k <= 6; k++) begin
         inj = 3'(k);
         rd(4, k, tag_of(4));
         rd(11, 7, 20'h1);
      end
      inj = 0;
      rd(4, 1, tag_of(4));

      // R6: flush injection per code
      cur_req = "R6";
      for (int k = 1; k <= 6; k++) begin
         inj = 3'(k);
         fl(5);
      end
      inj = 0;
      fl(5);

      // R11: simultaneous lookup and flush
      cur_req = "R11";
      inj = 3'd2;
      rd_en = 1; rd_set = 4'd6; rd_word = 3'd3; rd_tag = tag_of(6);
      fl_en = 1; fl_set = 4'd7;
      cyc(); idle_in();
      inj = 0;

      // R8: reporting disabled
      cur_req = "R8";
      par_en = 0;
      for (int k = 1; k <= 6; k++) begin
         inj = 3'(k);
         rd(8, 2, tag_of(8));
         fl(8);
      end
      inj = 0; par_en = 1;

      // R7 and R9: invalidate sweep, ignored requests while busy
      cur_req = "R7";
      inv_all = 1;
      cyc(); idle_in();
      cur_req = "R9";
      wtag(3, 20'h55555);
      rd(1, 0, tag_of(1));
      fl(1);
      wdat(1, 0, 32'hFFFFFFFF, 4'hF);
      inv_all = 1;
      cyc(); idle_in();
      for (int i = 0; i < 12; i++) cyc();
      cur_req = "R7";
      for (int i = 0; i < 3; i++) cyc();
      for (int s = 0; s < NS; s++) rd(s, 0, tag_of(s));
      rd(3, 0, 20'h55555);

      // R10: no report for invalid lines, set reported for valid ones
      cur_req = "R10";
      inj = 3'd2;
      rd(6, 0, tag_of(6));
      fl(6);
      inj = 0;
      wtag(13, 20'h0F0F0);
      inj = 3'd1;
      rd(13, 4, 20'h0F0F0);
      rd(12, 4, 20'h0F0F0);
      inj = 3'd5;
      fl(13);
      inj = 0;
      rd(13, 1, 20'h0F0F0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule